// File: doc/BRIEF.md
# Decimal Matrix Code Word Encoder

This block turns a 64-bit memory word into a 136-bit protected codeword ready to be written into an array. The word is treated as sixteen 4-bit symbols, laid out logically as two rows of eight. Row 0 is bits 31..0 and row 1 is bits 63..32. The bits themselves are not moved. Two kinds of check bits are added. Each horizontal check is a 5-bit unsigned sum of two symbols in the same row, with the carry kept. Each vertical check is the XOR of the two data bits that sit at the same column position in the two rows.

The codeword is `{vertical[31:0], horizontal[39:0], data[63:0]}`. The data field is copied through unchanged. Horizontal sum k lives at codeword bits `[64+5k +: 5]`. Sums 0..3 come from row 0 and sums 4..7 from row 1. Within a row, symbol j is added to symbol j+4.

Words enter and leave on valid/ready streams. A word moves when `in_valid` and `in_ready` are both high at a rising edge. A codeword is taken when `out_valid` and `out_ready` are both high. By default, one register stage sits on the output, and `in_ready` follows downstream back-pressure. A parameter can remove that stage, which leaves a purely combinational path with valid and ready passed straight through. A producer must hold `in_valid` and `in_data` steady until the word is accepted.

Top module: `dmc_encoder`

## Requirements
- R1: Codeword bits [63:0] equal the data word that was accepted, bit for bit.
- R2: For k = 0..7, with r = k/4 and j = k%4, codeword bits [64+5k +: 5] equal the unsigned sum of data symbol `[32r+4j +: 4]` and data symbol `[32r+4(j+4) +: 4]`, with the carry-out kept as bit 4.
- R3: For i = 0..31, codeword bit 104+i equals data[i] XOR data[i+32].
- R4: In registered mode, a word accepted at a rising edge is presented with `out_valid` high just after that edge. Codewords leave in the order their words were accepted.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_cw` stay unchanged across the edge.
- R6: `in_ready` is high exactly when the output stage is empty or `out_ready` is high.
- R7: Immediately after reset, `out_valid` is low and `in_ready` is high.
- R8: When every symbol is 4'hF, each horizontal sum is 5'b11110 (30), and the vertical field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Data word is offered |
| in_ready | output | 1 | Encoder can take a word this cycle |
| in_data | input | 64 | Data word to protect |
| out_valid | output | 1 | Codeword is presented |
| out_ready | input | 1 | Downstream takes the codeword |
| out_cw | output | 136 | Codeword {vertical, horizontal, data} |

## Verification
The all-zero word and the all-ones word are applied first. Together they separate a missing carry from a correct sum: all ones must give thirty in every horizontal slot and zero in every vertical bit. Next come words with a nibble of 4'hF in only one row, or in only the upper half of a row. These reveal a symbol paired with the wrong partner, or a sum placed in the wrong slot. Pseudo-random words then run under irregular gaps in `in_valid` and stalls on `out_ready`, including a long stall. These show that ordering holds, that nothing is lost or duplicated, and that the output is held while back-pressure lasts.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  localparam int DEF_SYM_W = 4;
  localparam int DEF_ROWS  = 2;
  localparam int DEF_COLS  = 8;

  // width of one pair sum: symbol width plus the carry
  function automatic int sum_width(input int sym_w);
    return sym_w + 1;
  endfunction
endpackage

// File: rtl/dmc_hsum.sv
module dmc_hsum #(
  parameter int SYM_W = dmc_pkg::DEF_SYM_W,
  parameter int ROWS  = dmc_pkg::DEF_ROWS,
  parameter int COLS  = dmc_pkg::DEF_COLS,
  localparam int ROW_W  = COLS * SYM_W,
  localparam int DATA_W = ROWS * ROW_W,
  localparam int HALF   = COLS / 2,
  localparam int HS_W   = dmc_pkg::sum_width(SYM_W),
  localparam int H_W    = ROWS * HALF * HS_W
) (
  input  logic [DATA_W-1:0] data,
  output logic [H_W-1:0]    hsum
);
  // symbol j of each row is added to symbol j+HALF of the same row
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar j = 0; j < HALF; j++) begin : g_pair
      logic [HS_W-1:0] lo_ext, hi_ext;
      assign lo_ext = {1'b0, data[r*ROW_W + j*SYM_W +: SYM_W]};
      assign hi_ext = {1'b0, data[r*ROW_W + (j+HALF)*SYM_W +: SYM_W]};
      assign hsum[(r*HALF + j)*HS_W +: HS_W] = lo_ext + hi_ext;
    end
  end
endmodule

// File: rtl/dmc_vpar.sv
module dmc_vpar #(
  parameter int SYM_W = dmc_pkg::DEF_SYM_W,
  parameter int ROWS  = dmc_pkg::DEF_ROWS,
  parameter int COLS  = dmc_pkg::DEF_COLS,
  localparam int ROW_W  = COLS * SYM_W,
  localparam int DATA_W = ROWS * ROW_W
) (
  input  logic [DATA_W-1:0] data,
  output logic [ROW_W-1:0]  vpar
);
  // parity down each bit column across all rows
  always_comb begin
    vpar = '0;
    for (int r = 0; r < ROWS; r++) vpar ^= data[r*ROW_W +: ROW_W];
  end
endmodule

// File: rtl/dmc_stage.sv
module dmc_stage #(
  parameter int W          = 136,
  parameter bit REGISTERED = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  if (REGISTERED) begin : g_reg
    logic         vld_q;
    logic [W-1:0] dat_q;

    assign in_ready  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign out_data  = dat_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        vld_q <= 1'b0;
      else if (in_ready) vld_q <= in_valid;
    end

    always_ff @(posedge clk) begin
      if (in_valid && in_ready) dat_q <= in_data;
    end

    assert_accept_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));
    assert_hold_on_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    assert_ready_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;

    assert_ready_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);
  end
endmodule

// File: rtl/dmc_encoder.sv
module dmc_encoder #(
  parameter int SYM_W      = dmc_pkg::DEF_SYM_W,
  parameter int ROWS       = dmc_pkg::DEF_ROWS,
  parameter int COLS       = dmc_pkg::DEF_COLS,
  parameter bit REGISTERED = 1'b1,
  localparam int ROW_W  = COLS * SYM_W,
  localparam int DATA_W = ROWS * ROW_W,
  localparam int HALF   = COLS / 2,
  localparam int HS_W   = dmc_pkg::sum_width(SYM_W),
  localparam int H_W    = ROWS * HALF * HS_W,
  localparam int V_W    = ROW_W,
  localparam int CW_W   = DATA_W + H_W + V_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CW_W-1:0]   out_cw
);
  logic [H_W-1:0]  hsum;
  logic [V_W-1:0]  vpar;
  logic [CW_W-1:0] cw_next;

  dmc_hsum #(.SYM_W(SYM_W), .ROWS(ROWS), .COLS(COLS)) u_hsum (
    .data(in_data), .hsum(hsum));

  dmc_vpar #(.SYM_W(SYM_W), .ROWS(ROWS), .COLS(COLS)) u_vpar (
    .data(in_data), .vpar(vpar));

  assign cw_next = {vpar, hsum, in_data};

  dmc_stage #(.W(CW_W), .REGISTERED(REGISTERED)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(cw_next),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_cw));

  // data field is the word that went in
  if (REGISTERED) begin : g_chk_reg
    assert_data_copy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_cw[DATA_W-1:0] == $past(in_data)));
  end else begin : g_chk_comb
    assert_data_copy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_cw[DATA_W-1:0] == in_data));
  end

  // each stored sum, minus its upper symbol, gives back its lower symbol
  for (genvar k = 0; k < ROWS*HALF; k++) begin : g_chk_h
    localparam int R = k / HALF;
    localparam int J = k % HALF;
    logic [HS_W-1:0] h_f, lo_f, hi_f;
    assign h_f  = out_cw[DATA_W + k*HS_W +: HS_W];
    assign lo_f = {1'b0, out_cw[R*ROW_W + J*SYM_W +: SYM_W]};
    assign hi_f = {1'b0, out_cw[R*ROW_W + (J+HALF)*SYM_W +: SYM_W]};
    assert_sum_recovers_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((h_f - hi_f) == lo_f));
  end

  // parity field folds the rows back to zero
  logic [V_W-1:0] v_fold;
  always_comb begin
    v_fold = out_cw[DATA_W + H_W +: V_W];
    for (int r = 0; r < ROWS; r++) v_fold ^= out_cw[r*ROW_W +: ROW_W];
  end
  assert_parity_folds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (v_fold == '0));
endmodule

// File: tb/tb_dmc_encoder.sv
module tb_dmc_encoder;
  localparam int NITEMS = 300;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [63:0]  in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [135:0] out_cw;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [135:0] sb_q[$];

  always #5 clk = ~clk;

  dmc_encoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_cw(out_cw));

  function automatic logic [135:0] model(input logic [63:0] d);
    logic [39:0] h;
    logic [31:0] v;
    for (int k = 0; k < 8; k++) begin
      int r = k / 4;
      int j = k % 4;
      h[k*5 +: 5] = 5'(d[r*32 + j*4 +: 4]) + 5'(d[r*32 + (j+4)*4 +: 4]);
    end
    v = d[31:0] ^ d[63:32];
    return {v, h, d};
  endfunction

  task automatic check(input string req, input logic [135:0] got, input logic [135:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] pattern(input int n, input logic [63:0] rnd);
    case (n)
      0: return 64'h0;
      1: return '1;
      2: return 64'h0000_000F_0000_000F;
      3: return 64'hF000_0000_F000_0000;
      4: return 64'h0000_0000_FFFF_FFFF;
      5: return 64'hFFFF_0000_0000_0000;
      6: return 64'h8421_8421_1248_1248;
      default: return rnd;
    endcase
  endfunction

  task automatic compare_item(input logic [135:0] got, input logic [135:0] exp);
    check("R1", {72'h0, got[63:0]},    {72'h0, exp[63:0]});
    check("R2", {96'h0, got[103:64]},  {96'h0, exp[103:64]});
    check("R3", {104'h0, got[135:104]}, {104'h0, exp[135:104]});
    if (exp[63:0] == '1) begin
      check("R8", {96'h0, got[103:64]},   {96'h0, {8{5'b11110}}});
      check("R8", {104'h0, got[135:104]}, 136'h0);
    end
  endtask

  initial begin : watchdog
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [63:0]  rnd = 64'h9E37_79B9_7F4A_7C15;
    logic [135:0] held_cw = '0;
    bit stall_pend = 1'b0;
    bit acc = 1'b0;
    int sent = 0;
    int cyc = 0;

    repeat (3) @(negedge clk);
    // R7: state while and right after reset
    check("R7", {135'h0, out_valid}, 136'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", {135'h0, out_valid}, 136'h0);
    check("R7", {135'h0, in_ready}, 136'h1);

    while (sent < NITEMS || sb_q.size() != 0) begin
      @(negedge clk);
      cyc++;
      // effects of the edge just passed
      if (acc) check("R4", {135'h0, out_valid}, 136'h1);
      if (stall_pend) begin
        check("R5", {135'h0, out_valid}, 136'h1);
        check("R5", out_cw, held_cw);
      end
      // new stimulus; a pending word is held until accepted
      if (!in_valid || acc) begin
        if (sent < NITEMS && (cyc % 7) != 2) begin
          rnd = rnd ^ (rnd << 13);
          rnd = rnd ^ (rnd >> 7);
          rnd = rnd ^ (rnd << 17);
          in_data  = pattern(sent, rnd);
          in_valid = 1'b1;
          sent++;
        end else begin
          in_valid = 1'b0;
        end
      end
      out_ready = (sent >= NITEMS) ? 1'b1 :
                  ((cyc % 5) != 3) && !(cyc >= 40 && cyc < 48);
      #1;
      check("R6", {135'h0, in_ready}, {135'h0, (!out_valid || out_ready)});
      acc = in_valid && in_ready;
      if (acc) sb_q.push_back(model(in_data));
      if (out_valid && out_ready) begin
        if (sb_q.size() == 0) begin
          errors++;
          checks++;
          $display("FAIL R4 got unexpected codeword %h expected none", out_cw);
        end else begin
          compare_item(out_cw, sb_q.pop_front());
        end
      end
      stall_pend = out_valid && !out_ready;
      held_cw = out_cw;
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule